// File: doc/BRIEF.md
# Timer Block MMIO Register Front End

This block is the software-visible register front end of a multi-channel event timer. A simple valid/ready register port carries 32-bit and 64-bit reads and writes to a fixed register window. The window holds a read-only capability word, a general configuration word, an interrupt status word, the free-running main counter, and three registers for each timer channel: configuration, comparator and message route.

Every register is 64 bits wide on the bus. A 4-byte access reaches one half of it, and a 8-byte access reaches the whole word. The block merges half-writes into the stored value. It keeps read-only capability fields intact and clears status bits when software writes a 1 to them. It also owns the 32-bit main counter: the counter advances on a tick strobe while it is enabled, holds its value while it is disabled, and can be loaded by software. Each channel's configuration, comparator and route leave the block as plain vectors. The comparator channels and the interrupt route selector, which sit outside this block, consume them. A one-cycle restart pulse tells the channels when the count base has changed.

Top module: `hpet_mmio_regs`

## Requirements
- R1: An access is accepted only with size code 2'b10 (4 bytes, address bits [1:0] zero) or 2'b11 (8 bytes, address bits [2:0] zero). A rejected write changes nothing, and a rejected read returns 0.
- R2: A 4-byte access with address bit 2 set reaches bits [63:32] of the register. Its write data lands in the upper half and leaves the lower half unchanged. Its read data returns the upper half in bits [31:0], with bits [63:32] zero.
- R3: The capability word at offset 0x000 has these fields: bits [7:0] = 1, bits [12:8] = channel count minus one, bit 13 = 0 (32-bit counter), bit 15 = 1 (legacy route capable), bits [31:16] = 0x8086, bits [63:32] = tick period in femtoseconds (100000000). Writes to it have no effect.
- R4: In the status word at 0x010, bit i is set by a pulse on chan_event[i]. Writing a 1 to a bit clears it, and writing a 0 leaves it unchanged. An event in the same cycle as a clear of the same bit keeps the bit set.
- R5: A write to the counter at 0x018 merges the data into the zero-extended 32-bit count and keeps the low 32 bits. When the counter is enabled, cnt_restart pulses in the cycle after the write.
- R6: The counter advances by one on each tick_en cycle while the enable bit is set, and holds its value while the bit is clear. Setting the enable bit resumes counting from the held value and pulses cnt_restart in the cycle after the write.
- R7: A channel configuration write changes only bits 1, 2, 3, 6, [13:9] and 14. Bits [63:32], 15 and 4 keep their reset value of ROUTE_CAP, 1 and 1. Bit 5 and bit 8 always read 0.
- R8: A comparator resets to 0xFFFFFFFF. A write merges the data into the zero-extended value, clears bit 6 of that channel's configuration, and pulses the channel's tmr_cmp_wr bit in the cycle after the write.
- R9: Channel n occupies 0x040 + 32*n, with configuration at +0x00, comparator at +0x08 and message route at +0x10. The message route is fully writable. Offsets +0x18, offsets beyond the last channel and any other unmapped offset read 0.
- R10: req_ready is always 1. rsp_valid is high for exactly the cycle after an accepted read, with rsp_rdata valid in that same cycle.
- R11: The general configuration word at 0x008 stores only bit 0 (counter enable, driven on cnt_run) and bit 1 (legacy route, driven on legacy_route). All other bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Register access request |
| req_ready | output | 1 | Always 1 |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte offset in the register window |
| req_size | input | 2 | Access size code (2'b10 = 4 bytes, 2'b11 = 8 bytes) |
| req_wdata | input | 64 | Write data (low 32 bits for 4-byte writes) |
| rsp_valid | output | 1 | Read data valid, one cycle after the read |
| rsp_rdata | output | 64 | Read data |
| tick_en | input | 1 | Counter tick strobe |
| chan_event | input | NT | Per-channel status set pulses |
| cnt_value | output | 32 | Main counter value |
| cnt_run | output | 1 | Counter enable bit |
| cnt_restart | output | 1 | Count base changed; channels re-arm |
| legacy_route | output | 1 | Legacy route bit |
| irq_status | output | NT | Status word bits |
| tmr_cfg | output | NT*64 | Channel configurations, channel n at [64n+63:64n] |
| tmr_cmp | output | NT*32 | Channel comparators, channel n at [32n+31:32n] |
| tmr_cmp_wr | output | NT | One-cycle comparator write pulse per channel |
| tmr_msg | output | NT*64 | Channel message routes |

## Verification
Every register write takes effect at the clock edge that accepts it. The new value, cnt_restart and tmr_cmp_wr can therefore be seen at the falling edge that follows. Read data and rsp_valid are registered at that same accepting edge and are sampled at that same falling edge. The count advances one step on each rising edge with tick_en high. The bench drives all inputs on falling edges and samples one falling edge after each request, so every check lands in the cycle its result is due. Counter reads are issued only with tick_en low, so the expected count is exact.

// File: rtl/hpr_pkg.sv
// Package: shared constants, register kinds and the lane-merge helper for
// the timer register front end. Assumes a 64-bit register view on the bus.
package hpr_pkg;

    localparam logic [1:0] SZ_WORD  = 2'b10;
    localparam logic [1:0] SZ_DWORD = 2'b11;

    localparam int unsigned OFS_CAP  = 32'h000;
    localparam int unsigned OFS_GCFG = 32'h008;
    localparam int unsigned OFS_STS  = 32'h010;
    localparam int unsigned OFS_CNT  = 32'h018;
    localparam int unsigned TMR_BASE = 32'h040;
    localparam int unsigned TMR_STEP = 32'h020;

    // Writable channel configuration bits: 1,2,3,6,13:9,14
    localparam logic [63:0] TCFG_WMASK = 64'h0000_0000_0000_7E4E;
    localparam int TB_VSET    = 6;
    localparam int TB_PERCAP  = 4;
    localparam int TB_FSBCAP  = 15;

    typedef enum logic [2:0] {
        RG_NONE, RG_CAP, RG_GCFG, RG_STS, RG_CNT, RG_TCFG, RG_TCMP, RG_TMSG
    } reg_kind_t;

    // Replace the masked lanes of old with data
    function automatic logic [63:0] lane_merge(input logic [63:0] old_v,
                                               input logic [63:0] data,
                                               input logic [63:0] mask);
        return (old_v & ~mask) | (data & mask);
    endfunction

endpackage

// File: rtl/hpr_access_decode.sv
// Access decoder: checks size and natural alignment, selects the addressed
// register and channel, and aligns write data and lane mask to 64 bits.
// Assumes the channel window fits inside the ADDR_W-bit offset space.
module hpr_access_decode
    import hpr_pkg::*;
#(
    parameter int NT     = 8,
    parameter int ADDR_W = 10,
    localparam int IDX_W = (NT > 1) ? $clog2(NT) : 1
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [1:0]        size,
    input  logic [63:0]       wdata,
    output logic              acc_ok,
    output logic              hi_half,
    output reg_kind_t         kind,
    output logic [IDX_W-1:0]  tidx,
    output logic [63:0]       wmask,
    output logic [63:0]       wdata_al
);
    localparam int unsigned TMR_END = TMR_BASE + TMR_STEP * NT;

    logic [31:0] a32;
    logic [31:0] toff;

    assign a32  = 32'(addr);
    assign toff = a32 - TMR_BASE;

    // Size and alignment acceptance
    always_comb begin
        acc_ok = ((size == SZ_WORD)  && (addr[1:0] == 2'b00)) ||
                 ((size == SZ_DWORD) && (addr[2:0] == 3'b000));
        hi_half = (size == SZ_WORD) && addr[2];
    end

    // Lane mask and data alignment for 32-bit half writes
    always_comb begin
        if (size == SZ_DWORD) begin
            wmask    = '1;
            wdata_al = wdata;
        end else if (hi_half) begin
            wmask    = {32'hFFFF_FFFF, 32'h0};
            wdata_al = {wdata[31:0], 32'h0};
        end else begin
            wmask    = {32'h0, 32'hFFFF_FFFF};
            wdata_al = {32'h0, wdata[31:0]};
        end
    end

    // Register and channel selection
    always_comb begin
        kind = RG_NONE;
        tidx = toff[5 +: IDX_W];
        if (a32[31:3] == OFS_CAP[31:3])       kind = RG_CAP;
        else if (a32[31:3] == OFS_GCFG[31:3]) kind = RG_GCFG;
        else if (a32[31:3] == OFS_STS[31:3])  kind = RG_STS;
        else if (a32[31:3] == OFS_CNT[31:3])  kind = RG_CNT;
        else if (a32 >= TMR_BASE && a32 < TMR_END) begin
            case (toff[4:3])
                2'd0:    kind = RG_TCFG;
                2'd1:    kind = RG_TCMP;
                2'd2:    kind = RG_TMSG;
                default: kind = RG_NONE;
            endcase
        end
    end

endmodule

// File: rtl/hpr_main_counter.sv
// Main counter and general configuration: holds the enable and legacy bits,
// counts tick strobes while enabled, accepts software loads and raises a
// one-cycle restart pulse when the count base changes while running.
// Assumes CW <= 64.
module hpr_main_counter
    import hpr_pkg::*;
#(
    parameter int CW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          gcfg_we,
    input  logic          cnt_we,
    input  logic [63:0]   wdata,
    input  logic [63:0]   wmask,
    output logic [CW-1:0] cnt,
    output logic [1:0]    gcfg,
    output logic          restart
);
    logic [63:0] gcfg_next;
    logic [63:0] cnt_merge;
    logic        run_next;

    assign gcfg_next = lane_merge({62'h0, gcfg}, wdata, wmask);
    assign cnt_merge = lane_merge(64'(cnt), wdata, wmask);
    assign run_next  = gcfg_we ? gcfg_next[0] : gcfg[0];

    // General configuration: only enable and legacy bits are stored
    always_ff @(posedge clk) begin
        if (!rst_n)       gcfg <= 2'b00;
        else if (gcfg_we) gcfg <= gcfg_next[1:0];
    end

    // Counter: software load has priority over a tick
    always_ff @(posedge clk) begin
        if (!rst_n)                cnt <= '0;
        else if (cnt_we)           cnt <= cnt_merge[CW-1:0];
        else if (gcfg[0] && tick)  cnt <= cnt + 1'b1;
    end

    // Restart pulse on a load while running or on the enable rising
    always_ff @(posedge clk) begin
        if (!rst_n) restart <= 1'b0;
        else        restart <= (cnt_we && gcfg[0]) || (run_next && !gcfg[0]);
    end

    AST_FROZEN_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (!gcfg[0] && !cnt_we) |=> $stable(cnt)); // R6
    AST_TICK_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (gcfg[0] && tick && !cnt_we) |=> (cnt == $past(cnt) + 1'b1)); // R6

endmodule

// File: rtl/hpr_irq_status.sv
// Interrupt status word: channel events set bits, software write-1 clears
// them; a same-cycle event wins over a clear. Assumes NT <= 32.
module hpr_irq_status #(
    parameter int NT = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NT-1:0] set,
    input  logic [NT-1:0] clr,
    output logic [NT-1:0] sts
);
    // Set-dominant write-1-to-clear update
    always_ff @(posedge clk) begin
        if (!rst_n) sts <= '0;
        else        sts <= (sts & ~clr) | set;
    end

    AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (|(clr & ~set)) |=> ((sts & $past(clr & ~set)) == '0)); // R4
    AST_EVENT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (|set) |=> ((sts & $past(set)) == $past(set))); // R4

endmodule

// File: rtl/hpr_timer_regs.sv
// One channel's registers: configuration with read-only capability fields,
// 32-bit comparator with write pulse, and a fully writable message route.
// Assumes at most one of the three write enables is high per cycle.
module hpr_timer_regs
    import hpr_pkg::*;
#(
    parameter logic [31:0] ROUTE_CAP = 32'h00F0_0000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cfg_we,
    input  logic        cmp_we,
    input  logic        msg_we,
    input  logic [63:0] wdata,
    input  logic [63:0] wmask,
    output logic [63:0] cfg,
    output logic [31:0] cmp,
    output logic        cmp_wr,
    output logic [63:0] msg
);
    localparam logic [63:0] CFG_RST = {ROUTE_CAP, 16'h0,
                                       16'((1 << TB_FSBCAP) | (1 << TB_PERCAP))};

    logic [63:0] cmp_merge;
    assign cmp_merge = lane_merge({32'h0, cmp}, wdata, wmask);

    // Configuration: only the writable mask reaches storage; value-set clears on comparator write
    always_ff @(posedge clk) begin
        if (!rst_n)      cfg <= CFG_RST;
        else if (cfg_we) cfg <= lane_merge(cfg, wdata, wmask & TCFG_WMASK);
        else if (cmp_we) cfg[TB_VSET] <= 1'b0;
    end

    // Comparator value and its write pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmp    <= 32'hFFFF_FFFF;
            cmp_wr <= 1'b0;
        end else begin
            cmp_wr <= cmp_we;
            if (cmp_we) cmp <= cmp_merge[31:0];
        end
    end

    // Message route register
    always_ff @(posedge clk) begin
        if (!rst_n)      msg <= '0;
        else if (msg_we) msg <= lane_merge(msg, wdata, wmask);
    end

    AST_VSET_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_we |=> !cfg[TB_VSET]); // R8
    AST_RO_FIELDS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |=> ({cfg[63:32], cfg[TB_FSBCAP], cfg[TB_PERCAP]} ==
                    $past({cfg[63:32], cfg[TB_FSBCAP], cfg[TB_PERCAP]}))); // R7

endmodule

// File: rtl/hpet_mmio_regs.sv
// Top: register front end of the timer block. Decodes accesses, routes
// writes to the counter, status and channel registers, and returns
// registered read data one cycle after an accepted read.
// Assumes one access per cycle; the port is always ready.
module hpet_mmio_regs
    import hpr_pkg::*;
#(
    parameter int          NT        = 8,
    parameter int          ADDR_W    = 10,
    parameter logic [31:0] ROUTE_CAP = 32'h00F0_0000,
    parameter logic [15:0] VENDOR    = 16'h8086,
    parameter logic [31:0] TICK_FS   = 32'd100_000_000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic             req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]       req_size,
    input  logic [63:0]      req_wdata,
    output logic             rsp_valid,
    output logic [63:0]      rsp_rdata,
    input  logic             tick_en,
    input  logic [NT-1:0]    chan_event,
    output logic [31:0]      cnt_value,
    output logic             cnt_run,
    output logic             cnt_restart,
    output logic             legacy_route,
    output logic [NT-1:0]    irq_status,
    output logic [NT*64-1:0] tmr_cfg,
    output logic [NT*32-1:0] tmr_cmp,
    output logic [NT-1:0]    tmr_cmp_wr,
    output logic [NT*64-1:0] tmr_msg
);
    localparam int IDX_W = (NT > 1) ? $clog2(NT) : 1;
    localparam logic [63:0] CAP_WORD = {TICK_FS, VENDOR, 1'b1, 1'b0, 1'b0,
                                        5'(NT - 1), 8'd1};

    logic             acc_ok, hi_half, wr_go, rd_go;
    reg_kind_t        kind;
    logic [IDX_W-1:0] tidx;
    logic [63:0]      wmask, wdata_al;
    logic [1:0]       gcfg;
    logic [63:0]      t_cfg [NT];
    logic [31:0]      t_cmp [NT];
    logic [63:0]      t_msg [NT];
    logic [63:0]      rd_full, rd_word;

    assign req_ready = 1'b1;
    assign wr_go = req_valid && req_write && acc_ok;
    assign rd_go = req_valid && !req_write;

    hpr_access_decode #(.NT(NT), .ADDR_W(ADDR_W)) u_dec (
        .addr(req_addr), .size(req_size), .wdata(req_wdata),
        .acc_ok(acc_ok), .hi_half(hi_half), .kind(kind), .tidx(tidx),
        .wmask(wmask), .wdata_al(wdata_al)
    );

    hpr_main_counter #(.CW(32)) u_cnt (
        .clk(clk), .rst_n(rst_n), .tick(tick_en),
        .gcfg_we(wr_go && kind == RG_GCFG), .cnt_we(wr_go && kind == RG_CNT),
        .wdata(wdata_al), .wmask(wmask),
        .cnt(cnt_value), .gcfg(gcfg), .restart(cnt_restart)
    );
    assign cnt_run      = gcfg[0];
    assign legacy_route = gcfg[1];

    hpr_irq_status #(.NT(NT)) u_sts (
        .clk(clk), .rst_n(rst_n), .set(chan_event),
        .clr((wr_go && kind == RG_STS) ? NT'(wdata_al & wmask) : '0),
        .sts(irq_status)
    );

    for (genvar g = 0; g < NT; g++) begin : g_tmr
        logic sel;
        assign sel = wr_go && (tidx == IDX_W'(g));
        hpr_timer_regs #(.ROUTE_CAP(ROUTE_CAP)) u_tmr (
            .clk(clk), .rst_n(rst_n),
            .cfg_we(sel && kind == RG_TCFG),
            .cmp_we(sel && kind == RG_TCMP),
            .msg_we(sel && kind == RG_TMSG),
            .wdata(wdata_al), .wmask(wmask),
            .cfg(t_cfg[g]), .cmp(t_cmp[g]), .cmp_wr(tmr_cmp_wr[g]), .msg(t_msg[g])
        );
        assign tmr_cfg[g*64 +: 64] = t_cfg[g];
        assign tmr_cmp[g*32 +: 32] = t_cmp[g];
        assign tmr_msg[g*64 +: 64] = t_msg[g];
    end

    // Read source selection; rejected or unmapped reads return zero
    always_comb begin
        rd_full = '0;
        if (acc_ok) begin
            case (kind)
                RG_CAP:  rd_full = CAP_WORD;
                RG_GCFG: rd_full = {62'h0, gcfg};
                RG_STS:  rd_full = 64'(irq_status);
                RG_CNT:  rd_full = {32'h0, cnt_value};
                RG_TCFG: rd_full = t_cfg[tidx];
                RG_TCMP: rd_full = {32'h0, t_cmp[tidx]};
                RG_TMSG: rd_full = t_msg[tidx];
                default: rd_full = '0;
            endcase
        end
        if (req_size == SZ_WORD)
            rd_word = hi_half ? {32'h0, rd_full[63:32]} : {32'h0, rd_full[31:0]};
        else
            rd_word = rd_full;
    end

    // Registered read response
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= rd_go;
            if (rd_go) rsp_rdata <= rd_word;
        end
    end

    AST_RSP_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(req_valid && !req_write)); // R10
    AST_REJECT_NO_CMP_WR: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && !acc_ok) |=> (tmr_cmp_wr == '0)); // R1

endmodule

// File: tb/tb_hpet_mmio_regs.sv
// Bench: directed corner cases plus seeded random channel-register traffic.
module tb_hpet_mmio_regs;
    localparam int NT = 8;
    localparam logic [63:0] CAP_EXP   = 64'h05F5_E100_8086_8701;
    localparam logic [63:0] CFG_RST   = 64'h00F0_0000_0000_8010;
    localparam logic [63:0] CFG_WM    = 64'h7E4E;

    logic clk = 1'b0, rst_n = 1'b0;
    logic req_valid = 1'b0, req_write = 1'b0, tick_en = 1'b0;
    logic [9:0] req_addr = '0;
    logic [1:0] req_size = 2'b11;
    logic [63:0] req_wdata = '0;
    logic [NT-1:0] chan_event = '0;
    logic req_ready, rsp_valid, cnt_run, cnt_restart, legacy_route;
    logic [63:0] rsp_rdata;
    logic [31:0] cnt_value;
    logic [NT-1:0] irq_status, tmr_cmp_wr;
    logic [NT*64-1:0] tmr_cfg, tmr_msg;
    logic [NT*32-1:0] tmr_cmp;

    int n_chk = 0, n_bad = 0;
    bit finished = 0;
    logic [63:0] m_cfg [NT];
    logic [63:0] m_msg [NT];
    logic [63:0] rv;

    always #10 clk = ~clk;

    hpet_mmio_regs dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_size(req_size),
        .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .tick_en(tick_en), .chan_event(chan_event), .cnt_value(cnt_value),
        .cnt_run(cnt_run), .cnt_restart(cnt_restart), .legacy_route(legacy_route),
        .irq_status(irq_status), .tmr_cfg(tmr_cfg), .tmr_cmp(tmr_cmp),
        .tmr_cmp_wr(tmr_cmp_wr), .tmr_msg(tmr_msg)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] lane_mask(input logic [9:0] a, input logic [1:0] s);
        if (s == 2'b11) return '1;
        return a[2] ? {32'hFFFF_FFFF, 32'h0} : {32'h0, 32'hFFFF_FFFF};
    endfunction

    function automatic logic [63:0] align_wd(input logic [9:0] a, input logic [1:0] s,
                                             input logic [63:0] d);
        if (s == 2'b11) return d;
        return a[2] ? {d[31:0], 32'h0} : {32'h0, d[31:0]};
    endfunction

    function automatic logic [63:0] view(input logic [9:0] a, input logic [1:0] s,
                                         input logic [63:0] full);
        if (s == 2'b11) return full;
        return a[2] ? {32'h0, full[63:32]} : {32'h0, full[31:0]};
    endfunction

    task automatic wr(input logic [9:0] a, input logic [1:0] s, input logic [63:0] d,
                      input logic [NT-1:0] ev = '0);
        @(negedge clk);
        req_valid = 1; req_write = 1; req_addr = a; req_size = s; req_wdata = d;
        chan_event = ev;
        @(negedge clk);
        req_valid = 0; req_write = 0; chan_event = '0;
    endtask

    task automatic rd(input logic [9:0] a, input logic [1:0] s, output logic [63:0] d);
        @(negedge clk);
        req_valid = 1; req_write = 0; req_addr = a; req_size = s;
        @(negedge clk);
        req_valid = 0;
        d = rsp_rdata;
        check("R10 rsp_valid after read", 64'(rsp_valid), 64'd1);
    endtask

    task automatic ticks(input int n);
        @(negedge clk);
        tick_en = 1;
        repeat (n) @(negedge clk);
        tick_en = 0;
    endtask

    function automatic logic [9:0] taddr(input int t, input int f);
        return 10'(32'h40 + 32 * t + 8 * f);
    endfunction

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin : main
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst_n = 1;
        for (int i = 0; i < NT; i++) begin m_cfg[i] = CFG_RST; m_msg[i] = '0; end

        // Reset state
        check("R10 ready", 64'(req_ready), 64'd1);
        check("R10 idle rsp_valid", 64'(rsp_valid), 64'd0);
        rd(10'h000, 2'b11, rv); check("R3 capability", rv, CAP_EXP);
        rd(10'h008, 2'b11, rv); check("R11 gcfg reset", rv, 64'd0);
        rd(10'h010, 2'b11, rv); check("R4 status reset", rv, 64'd0);
        rd(10'h018, 2'b11, rv); check("R6 counter reset", rv, 64'd0);
        rd(taddr(0, 0), 2'b11, rv); check("R7 cfg reset", rv, CFG_RST);
        rd(taddr(5, 1), 2'b11, rv); check("R8 cmp reset", rv, 64'hFFFF_FFFF);

        // Capability halves and read-only
        rd(10'h004, 2'b10, rv); check("R2 cap upper half", rv, 64'h05F5_E100);
        rd(10'h000, 2'b10, rv); check("R2 cap lower half", rv, 64'h8086_8701);
        wr(10'h000, 2'b11, '0);
        rd(10'h000, 2'b11, rv); check("R3 cap write ignored", rv, CAP_EXP);

        // General configuration
        wr(10'h008, 2'b11, '1);
        check("R11 legacy out", 64'(legacy_route), 64'd1);
        rd(10'h008, 2'b11, rv); check("R11 gcfg stored bits", rv, 64'd3);
        wr(10'h008, 2'b11, '0);
        wr(10'h018, 2'b11, '0);

        // Counter enable, freeze, resume
        wr(10'h008, 2'b11, 64'd1);
        check("R6 restart on enable", 64'(cnt_restart), 64'd1);
        ticks(5);
        rd(10'h018, 2'b11, rv); check("R6 counts while enabled", rv, 64'd5);
        wr(10'h008, 2'b11, 64'd0);
        ticks(3);
        rd(10'h018, 2'b11, rv); check("R6 frozen while disabled", rv, 64'd5);
        wr(10'h008, 2'b10, 64'd1);
        ticks(2);
        rd(10'h018, 2'b11, rv); check("R6 resumes from held value", rv, 64'd7);
        check("R6 cnt_value port", 64'(cnt_value), 64'd7);

        // Counter load
        wr(10'h018, 2'b11, 64'hAAAA_BBBB_1234_5678);
        check("R5 restart on load while running", 64'(cnt_restart), 64'd1);
        rd(10'h018, 2'b11, rv); check("R5 load zero-extended", rv, 64'h1234_5678);
        wr(10'h01C, 2'b10, 64'hFFFF);
        rd(10'h018, 2'b11, rv); check("R5 upper half load dropped", rv, 64'h1234_5678);
        wr(10'h008, 2'b11, 64'd0);
        wr(10'h018, 2'b10, 64'h10);
        check("R5 no restart while stopped", 64'(cnt_restart), 64'd0);
        rd(10'h018, 2'b11, rv); check("R5 load while stopped", rv, 64'h10);

        // Status set and write-1-to-clear
        wr(10'h3F8, 2'b11, '0, 8'h05);
        rd(10'h010, 2'b11, rv); check("R4 events set bits", rv, 64'h05);
        wr(10'h010, 2'b11, 64'h04);
        rd(10'h010, 2'b11, rv); check("R4 write one clears", rv, 64'h01);
        wr(10'h010, 2'b11, 64'h00);
        rd(10'h010, 2'b11, rv); check("R4 write zero no effect", rv, 64'h01);
        wr(10'h014, 2'b10, 64'hFF);
        rd(10'h010, 2'b11, rv); check("R4 upper half clears nothing", rv, 64'h01);
        wr(10'h010, 2'b11, 64'h01, 8'h01);
        check("R4 event wins over clear", 64'(irq_status), 64'h01);
        wr(10'h010, 2'b10, 64'h01);
        check("R4 cleared", 64'(irq_status), 64'h00);

        // Channel configuration read-only fields
        wr(taddr(3, 0), 2'b11, '1);
        rd(taddr(3, 0), 2'b11, rv); check("R7 ones write", rv, CFG_RST | CFG_WM);
        wr(taddr(3, 0), 2'b11, '0);
        rd(taddr(3, 0), 2'b11, rv); check("R7 zeros write keeps RO", rv, CFG_RST);
        check("R7 cfg port", tmr_cfg[3*64 +: 64], CFG_RST);

        // Comparator
        wr(taddr(2, 0), 2'b11, 64'h40);
        rd(taddr(2, 0), 2'b10, rv); check("R8 value-set stored", rv, 64'h8050);
        wr(taddr(2, 1), 2'b10, 64'h1234);
        check("R8 cmp_wr pulse", 64'(tmr_cmp_wr), 64'h04);
        rd(taddr(2, 1), 2'b11, rv); check("R8 cmp value", rv, 64'h1234);
        check("R8 cmp_wr one cycle", 64'(tmr_cmp_wr), 64'h00);
        rd(taddr(2, 0), 2'b11, rv); check("R8 value-set cleared", rv, CFG_RST);
        check("R8 cmp port", 64'(tmr_cmp[2*32 +: 32]), 64'h1234);

        // Rejected accesses
        wr(taddr(2, 1) + 10'd4, 2'b11, 64'h99);
        check("R1 misaligned no cmp_wr", 64'(tmr_cmp_wr), 64'h00);
        wr(taddr(2, 1), 2'b01, 64'h77);
        rd(taddr(2, 1), 2'b11, rv); check("R1 rejected writes ignored", rv, 64'h1234);
        rd(10'h004, 2'b11, rv); check("R1 misaligned read zero", rv, 64'd0);
        rd(10'h000, 2'b00, rv); check("R1 bad size read zero", rv, 64'd0);
        rd(10'h002, 2'b10, rv); check("R1 misaligned word read zero", rv, 64'd0);

        // Map and unmapped offsets
        wr(taddr(7, 2) + 10'd4, 2'b10, 64'hDEAD_BEEF);
        rd(taddr(7, 2), 2'b11, rv); check("R2 upper half write", rv, 64'hDEAD_BEEF_0000_0000);
        m_msg[7] = 64'hDEAD_BEEF_0000_0000;
        rd(10'h020, 2'b11, rv); check("R9 unmapped low", rv, 64'd0);
        rd(taddr(0, 3), 2'b11, rv); check("R9 channel gap", rv, 64'd0);
        rd(10'h140, 2'b11, rv); check("R9 beyond last channel", rv, 64'd0);

        // Seeded random channel traffic against a model
        for (int it = 0; it < 300; it++) begin
            int t, f;
            logic [1:0] s;
            logic [9:0] a;
            logic [63:0] d, m, w;
            t = int'($urandom % NT);
            f = ($urandom % 2 == 0) ? 0 : 2;
            s = ($urandom % 2 == 0) ? 2'b11 : 2'b10;
            a = taddr(t, f) + ((s == 2'b10 && $urandom % 2 == 1) ? 10'd4 : 10'd0);
            d = {$urandom, $urandom};
            m = lane_mask(a, s);
            w = align_wd(a, s, d);
            wr(a, s, d);
            if (f == 0) m_cfg[t] = (m_cfg[t] & ~(m & CFG_WM)) | (w & m & CFG_WM);
            else        m_msg[t] = (m_msg[t] & ~m) | (w & m);
            rd(a, s, rv);
            if (f == 0) check("R7 random cfg", rv, view(a, s, m_cfg[t]));
            else        check("R9 random msg", rv, view(a, s, m_msg[t]));
        end

        finished = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule